// File: doc/BRIEF.md
# Wormhole Output Virtual-Channel Allocator

This block sits at one output port of a five-port wormhole router (four neighbour directions plus the local port). Every input port keeps one queue per virtual channel. Each of those input queues presents the flit at its head, which has already been routed to this output. The block decides each cycle which single flit crosses the output link, and into which downstream virtual channel it goes.

A downstream virtual-channel buffer holds exactly one packet. A head flit may therefore claim a downstream channel only when that buffer reports empty and no packet holds it. Once claimed, the channel stays reserved to the claiming input queue until that packet's tail flit is sent. The claiming queue's data and tail flits then follow into the same channel. Competing flits are ordered by a rotating round-robin pointer, so no input queue starves. The accepted flit is registered onto the output link together with its downstream channel number.

Route computation and the flit storage itself sit outside the block. The port counts are package parameters; the flit payload width is a top-level parameter.

Top module: `vcOutArb`

## Requirements
- R1: After reset no input queue is acknowledged, `outValid` is low, and every downstream channel is unreserved.
- R2: The 2-bit flit type is encoded as data=00, head=01, tail=10 and single-flit packet=11. The accepted type is carried unchanged to `outType`.
- R3: A head flit is accepted only if some downstream channel has `dnEmpty` high and is unreserved. The lowest-numbered such channel is taken. With none available, the head waits.
- R4: An accepted head reserves its downstream channel for its own input queue. Data and tail flits are accepted only from the input queue holding a reservation, and go to that reserved channel. Data or tail flits from any other queue are never acknowledged.
- R5: A reservation ends at the clock edge that closes the cycle in which its tail flit is accepted. A waiting head can take that channel in the very next cycle.
- R6: A single-flit packet (type 11) needs an empty, unreserved channel like a head, but leaves no reservation behind.
- R7: Among eligible queues (requester index = port*2 + vc), the first one at or after the round-robin pointer wins. The pointer moves to the winner plus one (wrapping) only in a cycle with an acceptance; idle cycles leave it unchanged. It is zero after reset.
- R8: A flit acknowledged in cycle t appears on `outValid`/`outType`/`outData`/`outVc` in cycle t+1. In a cycle following one without an acknowledgement, `outValid` is low.
- R9: At most one bit of `inAck` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 10 | One bit per input queue: a flit for this output is waiting |
| inType | input | 20 | Flit type per input queue, 2 bits each |
| inData | input | 10*DATA_W | Flit payload per input queue |
| dnEmpty | input | 2 | Downstream channel buffer is empty |
| inAck | output | 10 | One-hot: this queue's flit is taken this cycle |
| outValid | output | 1 | Output link carries a flit |
| outType | output | 2 | Type of the flit on the link |
| outData | output | DATA_W | Payload on the link |
| outVc | output | 1 | Downstream channel of the flit on the link |

## Verification
A reservation that is wrongly kept or dropped shows at the ports within one cycle. A stale reservation leaves a waiting head unacknowledged in the cycle after a tail. A missing one lets a foreign data flit through, or sends a second head into a busy channel, which `outVc` shows on the next cycle. A pointer that drifts during idle cycles shows on the first contended cycle, as the wrong bit of `inAck`. The directed scenarios put each of these situations directly ahead of the cycle that would expose it.

// File: rtl/vcOutArbPkg.sv
package vcOutArbPkg;
  parameter int unsigned NUM_PORTS = 5;
  parameter int unsigned NUM_VCS   = 2;
  localparam int unsigned NUM_REQ  = NUM_PORTS * NUM_VCS;
  localparam int unsigned REQ_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int unsigned VC_W     = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1;

  typedef enum logic [1:0] {
    FLIT_DATA = 2'b00,
    FLIT_HEAD = 2'b01,
    FLIT_TAIL = 2'b10,
    FLIT_SOLO = 2'b11
  } flitType_e;

  typedef struct packed {
    logic             xfer;
    logic [REQ_W-1:0] winner;
    logic [VC_W-1:0]  vc;
    logic             lockSet;
    logic             lockClr;
  } xferStrobe_t;
endpackage

// File: rtl/rrPick.sv
module rrPick #(
  parameter int unsigned N     = 10,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] ptr,
  output logic             anyGnt,
  output logic [IDX_W-1:0] gntIdx
);
  always_comb begin
    int idx;
    anyGnt = 1'b0;
    gntIdx = '0;
    for (int k = 0; k < int'(N); k++) begin
      idx = int'(ptr) + k;
      if (idx >= int'(N)) idx = idx - int'(N);
      if (!anyGnt && req[idx]) begin
        anyGnt = 1'b1;
        gntIdx = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/vcArbCtrl.sv
module vcArbCtrl
  import vcOutArbPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_REQ-1:0]   inValid,
  input  logic [2*NUM_REQ-1:0] inType,
  input  logic [NUM_VCS-1:0]   dnEmpty,
  output xferStrobe_t          strobe
);
  logic [NUM_VCS-1:0]   locked;
  logic [REQ_W-1:0]     owner [NUM_VCS];
  logic [REQ_W-1:0]     rrPtr;
  logic [NUM_REQ-1:0]   ownsVc;
  logic [VC_W-1:0]      ownIdx [NUM_REQ];
  logic                 freeAny;
  logic [VC_W-1:0]      freeVc;
  logic [NUM_REQ-1:0]   elig;
  logic                 anyGnt;
  logic [REQ_W-1:0]     gntIdx;
  flitType_e            winType;

  // which downstream channel each requester holds
  always_comb begin
    for (int i = 0; i < int'(NUM_REQ); i++) begin
      ownsVc[i] = 1'b0;
      ownIdx[i] = '0;
      for (int v = 0; v < int'(NUM_VCS); v++) begin
        if (locked[v] && owner[v] == REQ_W'(i)) begin
          ownsVc[i] = 1'b1;
          ownIdx[i] = VC_W'(v);
        end
      end
    end
  end

  // lowest-numbered empty, unreserved downstream channel
  always_comb begin
    freeAny = 1'b0;
    freeVc  = '0;
    for (int v = int'(NUM_VCS) - 1; v >= 0; v--) begin
      if (dnEmpty[v] && !locked[v]) begin
        freeAny = 1'b1;
        freeVc  = VC_W'(v);
      end
    end
  end

  // eligibility: heads need a free channel, body flits need a reservation
  generate
    for (genvar g = 0; g < int'(NUM_REQ); g++) begin : gElig
      flitType_e reqType;
      assign reqType = flitType_e'(inType[2*g +: 2]);
      always_comb begin
        if (!inValid[g]) begin
          elig[g] = 1'b0;
        end else if (reqType == FLIT_HEAD || reqType == FLIT_SOLO) begin
          elig[g] = freeAny && !ownsVc[g];
        end else begin
          elig[g] = ownsVc[g];
        end
      end
    end
  endgenerate

  rrPick #(.N(NUM_REQ), .IDX_W(REQ_W)) u_pick (
    .req    (elig),
    .ptr    (rrPtr),
    .anyGnt (anyGnt),
    .gntIdx (gntIdx)
  );

  assign winType = flitType_e'(inType[2*gntIdx +: 2]);

  always_comb begin
    strobe.xfer    = anyGnt;
    strobe.winner  = gntIdx;
    strobe.lockSet = anyGnt && (winType == FLIT_HEAD);
    strobe.lockClr = anyGnt && (winType == FLIT_TAIL);
    if (winType == FLIT_HEAD || winType == FLIT_SOLO) strobe.vc = freeVc;
    else                                              strobe.vc = ownIdx[gntIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.xfer) begin
      rrPtr <= (strobe.winner == REQ_W'(NUM_REQ - 1)) ? '0 : strobe.winner + 1'b1;
    end
  end

  generate
    for (genvar v = 0; v < int'(NUM_VCS); v++) begin : gLock
      always_ff @(posedge clk) begin
        if (!rstN) begin
          locked[v] <= 1'b0;
          owner[v]  <= '0;
        end else if (strobe.vc == VC_W'(v)) begin
          if (strobe.lockSet) begin
            locked[v] <= 1'b1;
            owner[v]  <= strobe.winner;
          end else if (strobe.lockClr) begin
            locked[v] <= 1'b0;
          end
        end
      end

      AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        locked[v] && !(strobe.lockClr && strobe.vc == VC_W'(v))
        |=> locked[v] && $stable(owner[v])); // R4

      AST_TAIL_FREES: assert property (@(posedge clk) disable iff (!rstN)
        strobe.lockClr && strobe.vc == VC_W'(v) |=> !locked[v]); // R5
    end
  endgenerate

  AST_HEAD_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockSet |-> dnEmpty[strobe.vc] && !locked[strobe.vc]); // R3

  AST_SOLO_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer && winType == FLIT_SOLO && !locked[strobe.vc] |=> !locked[$past(strobe.vc)]); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xfer |=> $stable(rrPtr)); // R7

  AST_WIN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |-> inValid[strobe.winner]); // R4
endmodule

// File: rtl/vcArbDatapath.sv
module vcArbDatapath
  import vcOutArbPkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  xferStrobe_t               strobe,
  input  logic [2*NUM_REQ-1:0]      inType,
  input  logic [DATA_W*NUM_REQ-1:0] inData,
  output logic [NUM_REQ-1:0]        inAck,
  output logic                      outValid,
  output logic [1:0]                outType,
  output logic [DATA_W-1:0]         outData,
  output logic [VC_W-1:0]           outVc
);
  generate
    for (genvar g = 0; g < int'(NUM_REQ); g++) begin : gAck
      assign inAck[g] = strobe.xfer && (strobe.winner == REQ_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outType  <= 2'b00;
      outData  <= '0;
      outVc    <= '0;
    end else begin
      outValid <= strobe.xfer;
      if (strobe.xfer) begin
        outType <= inType[2*strobe.winner +: 2];
        outData <= inData[DATA_W*strobe.winner +: DATA_W];
        outVc   <= strobe.vc;
      end
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inAck)); // R9

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (|inAck) |=> outValid); // R8

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(|inAck) |=> !outValid); // R8
endmodule

// File: rtl/vcOutArb.sv
module vcOutArb
  import vcOutArbPkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        inValid,
  input  logic [2*NUM_REQ-1:0]      inType,
  input  logic [DATA_W*NUM_REQ-1:0] inData,
  input  logic [NUM_VCS-1:0]        dnEmpty,
  output logic [NUM_REQ-1:0]        inAck,
  output logic                      outValid,
  output logic [1:0]                outType,
  output logic [DATA_W-1:0]         outData,
  output logic [VC_W-1:0]           outVc
);
  xferStrobe_t strobe;

  vcArbCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inType  (inType),
    .dnEmpty (dnEmpty),
    .strobe  (strobe)
  );

  vcArbDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inType   (inType),
    .inData   (inData),
    .inAck    (inAck),
    .outValid (outValid),
    .outType  (outType),
    .outData  (outData),
    .outVc    (outVc)
  );
endmodule

// File: tb/vcOutArb_tb.sv
module vcOutArb_tb;
  localparam int NREQ = 10;
  localparam int DW   = 16;
  localparam logic [1:0] T_DATA = 2'b00, T_HEAD = 2'b01, T_TAIL = 2'b10, T_SOLO = 2'b11;

  logic             clk = 1'b0;
  logic             rstN;
  logic [NREQ-1:0]  inValid;
  logic [2*NREQ-1:0] inType;
  logic [DW*NREQ-1:0] inData;
  logic [1:0]       dnEmpty;
  logic [NREQ-1:0]  inAck;
  logic             outValid;
  logic [1:0]       outType;
  logic [DW-1:0]    outData;
  logic             outVc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vcOutArb #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inType(inType), .inData(inData),
    .dnEmpty(dnEmpty), .inAck(inAck), .outValid(outValid), .outType(outType),
    .outData(outData), .outVc(outVc)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic setReq(input int i, input bit v, input logic [1:0] t, input logic [DW-1:0] d);
    inValid[i]        = v;
    inType[2*i +: 2]  = t;
    inData[DW*i +: DW] = d;
  endtask

  task automatic resetDut();
    inValid = '0; inType = '0; inData = '0; dnEmpty = 2'b11;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // inputs already set at a negedge; check ack now, output after the edge
  task automatic step(input int expAck, input logic [1:0] expType, input logic [DW-1:0] expData,
                      input bit expVc, input string tag);
    logic [NREQ-1:0] ea;
    ea = (expAck < 0) ? '0 : NREQ'(1) << expAck;
    #1;
    check(inAck == ea, {tag, " ack"}, $sformatf("%b", inAck), $sformatf("%b", ea));
    @(posedge clk);
    @(negedge clk);
    if (expAck < 0) begin
      check(outValid == 1'b0, {tag, " idle out"}, $sformatf("%b", outValid), "0");
    end else begin
      check(outValid && outType == expType && outData == expData && outVc == expVc,
            {tag, " out"},
            $sformatf("v=%b t=%b d=%h vc=%0d", outValid, outType, outData, outVc),
            $sformatf("v=1 t=%b d=%h vc=%0d", expType, expData, expVc));
    end
  endtask

  task automatic testReset();
    resetDut();
    #1;
    check(inAck == '0 && outValid == 1'b0, "R1 reset state",
          $sformatf("ack=%b v=%b", inAck, outValid), "ack=0 v=0");
    // all channels free: a head goes to vc0, a second one to vc1
    setReq(0, 1, T_HEAD, 16'h0A01);
    step(0, T_HEAD, 16'h0A01, 1'b0, "R1 free after reset");
    setReq(0, 0, T_DATA, 0);
    setReq(2, 1, T_HEAD, 16'h0A02);
    step(2, T_HEAD, 16'h0A02, 1'b1, "R1 second channel free");
    setReq(2, 0, T_DATA, 0);
  endtask

  task automatic testLock();
    resetDut();
    setReq(3, 1, T_HEAD, 16'h3001);
    step(3, T_HEAD, 16'h3001, 1'b0, "R2 head c1");
    setReq(3, 1, T_DATA, 16'h3002);
    setReq(5, 1, T_HEAD, 16'h5001);
    step(5, T_HEAD, 16'h5001, 1'b1, "R3 second head to vc1");
    setReq(5, 1, T_DATA, 16'h5002);
    setReq(7, 1, T_HEAD, 16'h7001);
    step(3, T_DATA, 16'h3002, 1'b0, "R4 head blocked, owner data to vc0");
    setReq(3, 1, T_TAIL, 16'h3003);
    step(5, T_DATA, 16'h5002, 1'b1, "R4 owner data to vc1");
    setReq(5, 1, T_TAIL, 16'h5003);
    step(3, T_TAIL, 16'h3003, 1'b0, "R2 tail on vc0");
    setReq(3, 0, T_DATA, 0);
    setReq(5, 0, T_DATA, 0);
    step(7, T_HEAD, 16'h7001, 1'b0, "R5 head right after tail");
    setReq(7, 0, T_DATA, 0);
    setReq(5, 1, T_TAIL, 16'h5003);
    step(5, T_TAIL, 16'h5003, 1'b1, "R5 other tail");
    setReq(5, 0, T_DATA, 0);
  endtask

  task automatic testForeign();
    resetDut();
    setReq(8, 1, T_DATA, 16'h8002);
    step(-1, T_DATA, 0, 1'b0, "R4 foreign data ignored");
    setReq(8, 1, T_TAIL, 16'h8003);
    step(-1, T_DATA, 0, 1'b0, "R4 foreign tail ignored");
    setReq(8, 0, T_DATA, 0);
  endtask

  task automatic testEmpty();
    resetDut();
    dnEmpty = 2'b10;
    setReq(2, 1, T_HEAD, 16'h2001);
    step(2, T_HEAD, 16'h2001, 1'b1, "R3 skip non-empty vc0");
    setReq(2, 0, T_DATA, 0);
    dnEmpty = 2'b00;
    setReq(4, 1, T_HEAD, 16'h4001);
    step(-1, T_DATA, 0, 1'b0, "R3 no empty channel");
    dnEmpty = 2'b01;
    step(4, T_HEAD, 16'h4001, 1'b0, "R3 vc0 drains");
    setReq(4, 0, T_DATA, 0);
    dnEmpty = 2'b11;
  endtask

  task automatic testSolo();
    resetDut();
    setReq(1, 1, T_SOLO, 16'h1111);
    step(1, T_SOLO, 16'h1111, 1'b0, "R6 single flit");
    setReq(1, 1, T_SOLO, 16'h1112);
    step(1, T_SOLO, 16'h1112, 1'b0, "R6 no lock left");
    setReq(1, 0, T_DATA, 0);
  endtask

  task automatic testRoundRobin();
    resetDut();
    setReq(0, 1, T_SOLO, 16'h0001);
    setReq(4, 1, T_SOLO, 16'h0004);
    setReq(7, 1, T_SOLO, 16'h0007);
    step(0, T_SOLO, 16'h0001, 1'b0, "R7 rr first");
    step(4, T_SOLO, 16'h0004, 1'b0, "R7 rr second");
    step(7, T_SOLO, 16'h0007, 1'b0, "R7 rr third");
    step(0, T_SOLO, 16'h0001, 1'b0, "R7 rr wrap");
    inValid = '0;
    step(-1, T_DATA, 0, 1'b0, "R8 idle cycle");
    setReq(0, 1, T_SOLO, 16'h0001);
    setReq(9, 1, T_SOLO, 16'h0009);
    step(9, T_SOLO, 16'h0009, 1'b0, "R7 pointer held over idle");
    inValid = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testLock();
    testForeign();
    testEmpty();
    testSolo();
    testRoundRobin();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule